// File: doc/BRIEF.md
# Memory Sub-Channel Event Counter Unit

This unit watches one memory sub-channel and keeps a running tally of the work it receives. A free-running cycle counter runs on the controller core clock. Beside it sits a bank of general counters. Each general counter can be pointed at one class of host-side command: reads, writes, or read-modify-writes. The controller raises a one-cycle pulse for each command it accepts. Software divides the command counts by the cycle count to derive bandwidth.

Software sees the unit through a small word-addressed register port with separate read and write strobes. The top two address bits select a region:

| Region | Address | Contents |
|---|---|---|
| Miscellaneous | index 0 | Control |
| Miscellaneous | index 1 | Cycle count, low half |
| Miscellaneous | index 2 | Cycle count, high half |
| Counter values | 1 | One entry per counter |
| Counter configuration | 2 | One entry per counter |

The cycle count is twice the data width. Software reads it low half first. That read captures the high half, so the pair is coherent. There is no sampling or interrupt path. Counts are only ever read out.

Top module: `memc_evt_mon`

## Requirements
- R1: After a synchronous active-low reset, every register reads as zero:
  - the control register;
  - both cycle halves;
  - every counter value;
  - every configuration entry.
- R2: The cycle counter advances by exactly one on each clock edge at which the run bit (control bit 0) is set. It holds its value while the run bit is clear.
- R3: Reading the low half (misc index 1) returns the low half of the cycle count and captures the high half at that edge. A later read of the high half (misc index 2) returns the captured value, whatever the counter has done since.
- R4: A counter configuration entry holds an event code in bits 2:0 and a per-counter enable in bit 3. The codes are 1 = read pulse, 2 = write pulse, 3 = read-modify-write pulse. A counter gains one on each edge at which its selected pulse is high, its enable is set and the run bit is set.
- R5: A counter whose code is 0 or 4 to 7, or whose enable bit is clear, does not change on any event pulse. A counter also does not change while the run bit is clear.
- R6: A counter that holds all ones stays at all ones when a counted event arrives. That event sets the counter's sticky overflow flag, which reads as bit 4 of its configuration entry. Software writes to bit 4 are ignored.
- R7: Writing control with bit 1 set zeroes, in one cycle:
  - the cycle counter;
  - the captured high half;
  - every counter;
  - every overflow flag.
  The run bit takes bit 0 of the same write. Configuration entries are kept.
- R8: When a software write to a counter value and a counted event reach that counter on the same edge, the counter takes the written value.
- R9: Read data appears on `rdata` one cycle after the `rd_en` edge and holds until the next read. Unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ev_rd | input | 1 | Read command accepted pulse |
| ev_wr | input | 1 | Write command accepted pulse |
| ev_rmw | input | 1 | Read-modify-write command accepted pulse |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register word address |
| wdata | input | DATA_W | Register write data |
| rdata | output | DATA_W | Registered read data |

## Verification
Several results are due one edge after their cause:
- Register writes and control changes take effect at the edge that samples the strobe.
- An event pulse is counted at the edge that samples it.
- Read data is registered and is due one cycle after the read strobe.

The bench drives every input on the falling edge. A reference model then advances on the rising edge from the same inputs. The bench compares `rdata` with the model's expected word at the next falling edge, one full cycle after the read was issued. The cycle counter's coherence is checked by leaving several hundred cycles between the low and high reads.

// File: rtl/memc_evt_pkg.sv
// Package: shared codes and register map constants for the event counter unit.
// Assumes the address is split into a 2-bit region and an index below it.
package memc_evt_pkg;
    localparam int CODE_W = 3;
    localparam int CFG_W  = 5;

    typedef enum logic [CODE_W-1:0] {
        EV_OFF = 3'd0,
        EV_RD  = 3'd1,
        EV_WR  = 3'd2,
        EV_RMW = 3'd3
    } ev_code_e;

    localparam int CFG_EN_BIT  = 3;
    localparam int CFG_OVF_BIT = 4;

    localparam logic [1:0] RGN_MISC = 2'b00;
    localparam logic [1:0] RGN_CNT  = 2'b01;
    localparam logic [1:0] RGN_CFG  = 2'b10;

    localparam int MISC_CTRL   = 0;
    localparam int MISC_CYC_LO = 1;
    localparam int MISC_CYC_HI = 2;

    localparam int CTRL_RUN_BIT = 0;
    localparam int CTRL_CLR_BIT = 1;
endpackage

// File: rtl/memc_cyc_ctr.sv
// Module: free-running cycle counter of 2*HALF_W bits with a high-half shadow.
// A snap strobe (low-half read) copies the high half into the shadow register.
// Assumes clr and snap are single-cycle strobes from the register decoder.
module memc_cyc_ctr #(
    parameter int HALF_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              clr,
    input  logic              snap,
    output logic [HALF_W-1:0] lo_o,
    output logic [HALF_W-1:0] hi_shadow_o
);
    localparam int FULL_W = 2 * HALF_W;

    logic [FULL_W-1:0] cnt_q;
    logic [HALF_W-1:0] shadow_q;

    // Count core clocks while running; clear has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt_q <= '0;
        else if (clr) cnt_q <= '0;
        else if (run) cnt_q <= cnt_q + FULL_W'(1);
    end

    // Capture the high half when software reads the low half.
    always_ff @(posedge clk) begin
        if (!rst_n)    shadow_q <= '0;
        else if (clr)  shadow_q <= '0;
        else if (snap) shadow_q <= cnt_q[FULL_W-1:HALF_W];
    end

    assign lo_o        = cnt_q[HALF_W-1:0];
    assign hi_shadow_o = shadow_q;

    a_r2_cyc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clr) |=> cnt_q == $past(cnt_q) + FULL_W'(1));
    a_r2_cyc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(cnt_q));
    a_r3_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!snap && !clr) |=> $stable(shadow_q));
    a_r7_cyc_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0 && shadow_q == '0));
endmodule

// File: rtl/memc_evt_ctr.sv
// Module: one saturating event counter with its configuration and sticky overflow.
// Assumes event pulses last one cycle each and that cnt_we and cfg_we are
// mutually exclusive with clr (one shared write port).
module memc_evt_ctr
    import memc_evt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              clr,
    input  logic              ev_rd,
    input  logic              ev_wr,
    input  logic              ev_rmw,
    input  logic              cfg_we,
    input  logic              cnt_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cnt_o,
    output logic [CFG_W-1:0]  cfg_o
);
    ev_code_e          code_q;
    logic              en_q;
    logic              ovf_q;
    logic [DATA_W-1:0] cnt_q;
    logic              hit;
    logic              count_ok;
    logic              at_max;

    // Select the pulse named by the event code; other codes never hit.
    always_comb begin
        unique case (code_q)
            EV_RD:   hit = ev_rd;
            EV_WR:   hit = ev_wr;
            EV_RMW:  hit = ev_rmw;
            default: hit = 1'b0;
        endcase
    end

    assign count_ok = run && en_q && hit;
    assign at_max   = &cnt_q;

    // Hold the event selection and per-counter enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= EV_OFF;
            en_q   <= 1'b0;
        end else if (cfg_we) begin
            code_q <= ev_code_e'(wdata[CODE_W-1:0]);
            en_q   <= wdata[CFG_EN_BIT];
        end
    end

    // Counter value: clear, then software write, then saturating increment.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt_q <= '0;
        else if (clr)                 cnt_q <= '0;
        else if (cnt_we)              cnt_q <= wdata;
        else if (count_ok && !at_max) cnt_q <= cnt_q + DATA_W'(1);
    end

    // Sticky flag for an event lost at full scale.
    always_ff @(posedge clk) begin
        if (!rst_n)                           ovf_q <= 1'b0;
        else if (clr)                         ovf_q <= 1'b0;
        else if (count_ok && at_max && !cnt_we) ovf_q <= 1'b1;
    end

    assign cnt_o = cnt_q;
    assign cfg_o = {ovf_q, en_q, code_q};

    a_r5_no_count: assert property (@(posedge clk) disable iff (!rst_n)
        ((!run || !en_q) && !cnt_we && !clr) |=> $stable(cnt_q));
    a_r6_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (at_max && !cnt_we && !clr) |=> (&cnt_q));
    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !clr) |=> ovf_q);
    a_r7_ctr_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0 && !ovf_q));
    a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_we && !clr) |=> cnt_q == $past(wdata));
endmodule

// File: rtl/memc_evt_mon.sv
// Module: top of the event counter unit: register decode, control, read mux.
// Address = {region[1:0], index[ADDR_W-3:0]}. Assumes N_CTR <= 2**(ADDR_W-2)
// and DATA_W >= 5 so a configuration entry fits one word.
module memc_evt_mon
    import memc_evt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int N_CTR  = 16,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_rd,
    input  logic              ev_wr,
    input  logic              ev_rmw,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int IDX_W = ADDR_W - 2;

    logic [1:0]        rgn;
    logic [IDX_W-1:0]  idx;
    logic              idx_ok;
    logic              ctrl_we;
    logic              clr;
    logic              snap;
    logic              run_q;
    logic [DATA_W-1:0] cyc_lo;
    logic [DATA_W-1:0] cyc_hi;
    logic [DATA_W-1:0] cnt_all [N_CTR];
    logic [CFG_W-1:0]  cfg_all [N_CTR];
    logic [DATA_W-1:0] rdata_d;
    logic [DATA_W-1:0] rdata_q;

    assign rgn     = addr[ADDR_W-1 -: 2];
    assign idx     = addr[IDX_W-1:0];
    assign idx_ok  = {1'b0, idx} < (IDX_W+1)'(N_CTR);
    assign ctrl_we = wr_en && rgn == RGN_MISC && idx == IDX_W'(MISC_CTRL);
    assign clr     = ctrl_we && wdata[CTRL_CLR_BIT];
    assign snap    = rd_en && rgn == RGN_MISC && idx == IDX_W'(MISC_CYC_LO);

    // Global run bit, loaded on every control write.
    always_ff @(posedge clk) begin
        if (!rst_n)       run_q <= 1'b0;
        else if (ctrl_we) run_q <= wdata[CTRL_RUN_BIT];
    end

    memc_cyc_ctr #(.HALF_W(DATA_W)) u_cyc (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run_q),
        .clr         (clr),
        .snap        (snap),
        .lo_o        (cyc_lo),
        .hi_shadow_o (cyc_hi)
    );

    for (genvar g = 0; g < N_CTR; g++) begin : g_ctr
        memc_evt_ctr #(.DATA_W(DATA_W)) u_ctr (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (run_q),
            .clr    (clr),
            .ev_rd  (ev_rd),
            .ev_wr  (ev_wr),
            .ev_rmw (ev_rmw),
            .cfg_we (wr_en && rgn == RGN_CFG && idx == IDX_W'(g)),
            .cnt_we (wr_en && rgn == RGN_CNT && idx == IDX_W'(g)),
            .wdata  (wdata),
            .cnt_o  (cnt_all[g]),
            .cfg_o  (cfg_all[g])
        );
    end

    // Select the word for the addressed register; unmapped reads give zero.
    always_comb begin
        rdata_d = '0;
        unique case (rgn)
            RGN_MISC: begin
                if (idx == IDX_W'(MISC_CTRL))        rdata_d = DATA_W'(run_q);
                else if (idx == IDX_W'(MISC_CYC_LO)) rdata_d = cyc_lo;
                else if (idx == IDX_W'(MISC_CYC_HI)) rdata_d = cyc_hi;
            end
            RGN_CNT: if (idx_ok) rdata_d = cnt_all[idx];
            RGN_CFG: if (idx_ok) rdata_d = DATA_W'(cfg_all[idx]);
            default: rdata_d = '0;
        endcase
    end

    // Register read data on a read strobe and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;

    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rgn == 2'b11) |=> rdata == '0);
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
endmodule

// File: tb/test_memc_evt_mon.sv
`timescale 1ns/1ps
module test_memc_evt_mon;
    localparam int DW = 8;
    localparam int NC = 16;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ev_rd = 1'b0, ev_wr = 1'b0, ev_rmw = 1'b0;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    memc_evt_mon #(.DATA_W(DW), .N_CTR(NC), .ADDR_W(AW)) i_memc_evt_mon (
        .clk(clk), .rst_n(rst_n), .ev_rd(ev_rd), .ev_wr(ev_wr), .ev_rmw(ev_rmw),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    // Reference model built from the requirements
    logic          m_run;
    logic [2*DW-1:0] m_cyc;
    logic [DW-1:0] m_shadow;
    logic [DW-1:0] m_cnt [NC];
    logic [2:0]    m_code [NC];
    logic          m_en [NC];
    logic          m_ovf [NC];
    logic [DW-1:0] m_rdata;

    function automatic logic [DW-1:0] f_read(input logic [AW-1:0] a);
        logic [1:0] r = a[AW-1 -: 2];
        int i = int'(a[AW-3:0]);
        case (r)
            2'b00: begin
                if (i == 0) return DW'(m_run);
                if (i == 1) return m_cyc[DW-1:0];
                if (i == 2) return m_shadow;
                return '0;
            end
            2'b01: return m_cnt[i];
            2'b10: return DW'({m_ovf[i], m_en[i], m_code[i]});
            default: return '0;
        endcase
    endfunction

    function automatic logic f_hit(input logic [2:0] c, input logic r, w, m);
        return (c == 3'd1 && r) || (c == 3'd2 && w) || (c == 3'd3 && m);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run <= 0; m_cyc <= '0; m_shadow <= '0; m_rdata <= '0;
            for (int i = 0; i < NC; i++) begin
                m_cnt[i] <= '0; m_code[i] <= '0; m_en[i] <= 0; m_ovf[i] <= 0;
            end
        end else begin
            logic clr_now;
            clr_now = wr_en && addr == 6'd0 && wdata[1];
            if (rd_en) m_rdata <= f_read(addr);
            if (clr_now) m_cyc <= '0;
            else if (m_run) m_cyc <= m_cyc + 1'b1;
            if (clr_now) m_shadow <= '0;
            else if (rd_en && addr == 6'd1) m_shadow <= m_cyc[2*DW-1:DW];
            if (wr_en && addr == 6'd0) m_run <= wdata[0];
            for (int i = 0; i < NC; i++) begin
                if (clr_now) begin
                    m_cnt[i] <= '0; m_ovf[i] <= 0;
                end else if (wr_en && addr == AW'(16 + i)) begin
                    m_cnt[i] <= wdata;
                end else if (m_run && m_en[i] && f_hit(m_code[i], ev_rd, ev_wr, ev_rmw)) begin
                    if (&m_cnt[i]) m_ovf[i] <= 1'b1;
                    else m_cnt[i] <= m_cnt[i] + 1'b1;
                end
                if (wr_en && addr == AW'(32 + i)) begin
                    m_code[i] <= wdata[2:0]; m_en[i] <= wdata[3];
                end
            end
        end
    end

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One cycle of stimulus, driven at the falling edge; returns at the next one.
    task automatic op(input logic [2:0] ev, input logic w, input logic r,
                      input logic [AW-1:0] a, input logic [DW-1:0] d);
        {ev_rmw, ev_wr, ev_rd} = ev;
        wr_en = w; rd_en = r; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 0; rd_en = 0; {ev_rmw, ev_wr, ev_rd} = 3'b000;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) op(3'b000, 0, 0, '0, '0);
    endtask

    task automatic rd_chk(input string req, input logic [AW-1:0] a);
        op(3'b000, 0, 1, a, '0);
        check(req, rdata, m_rdata);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] hi_cap;
        void'($urandom(32'd4242));
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every register class
        rd_chk("R1 ctrl", 6'd0);   check("R1 ctrl lit", rdata, 8'h00);
        rd_chk("R1 cyc lo", 6'd1); check("R1 cyc lo lit", rdata, 8'h00);
        rd_chk("R1 cyc hi", 6'd2);
        rd_chk("R1 cnt0", 6'd16);  check("R1 cnt0 lit", rdata, 8'h00);
        rd_chk("R1 cfg15", 6'd47);

        // R4: counter 0 on reads, 1 on writes, 2 on rmw
        op(3'b000, 1, 0, 6'd32, 8'h09);
        op(3'b000, 1, 0, 6'd33, 8'h0A);
        op(3'b000, 1, 0, 6'd34, 8'h0B);
        op(3'b000, 1, 0, 6'd35, 8'h0D);  // R5: code 5 counts nothing
        op(3'b000, 1, 0, 6'd36, 8'h01);  // R5: enable clear counts nothing
        op(3'b111, 0, 0, '0, '0);        // R5: run clear, nothing counts
        op(3'b000, 1, 0, 6'd0, 8'h01);   // run
        op(3'b001, 0, 0, '0, '0);
        op(3'b011, 0, 0, '0, '0);
        op(3'b111, 0, 0, '0, '0);
        rd_chk("R4 read count", 6'd16);  check("R4 read lit", rdata, 8'd3);
        rd_chk("R4 write count", 6'd17); check("R4 write lit", rdata, 8'd2);
        rd_chk("R4 rmw count", 6'd18);   check("R4 rmw lit", rdata, 8'd1);
        rd_chk("R5 bad code", 6'd19);    check("R5 bad code lit", rdata, 8'd0);
        rd_chk("R5 disabled", 6'd20);    check("R5 disabled lit", rdata, 8'd0);

        // R6: saturation and sticky overflow, ovf bit write ignored
        op(3'b000, 1, 0, 6'd16, 8'hFE);
        op(3'b001, 0, 0, '0, '0);
        op(3'b001, 0, 0, '0, '0);
        op(3'b001, 0, 0, '0, '0);
        rd_chk("R6 saturated", 6'd16);  check("R6 sat lit", rdata, 8'hFF);
        rd_chk("R6 ovf flag", 6'd32);   check("R6 ovf lit", rdata, 8'h19);
        op(3'b000, 1, 0, 6'd32, 8'h09);
        rd_chk("R6 ovf sticky", 6'd32); check("R6 sticky lit", rdata, 8'h19);

        // R8: software write beats a same-cycle event
        op(3'b001, 1, 0, 6'd16, 8'h40);
        rd_chk("R8 write wins", 6'd16); check("R8 lit", rdata, 8'h40);

        // R2: cycle counter steps while running, holds while stopped
        rd_chk("R2 cyc lo a", 6'd1);
        idle(7);
        rd_chk("R2 cyc lo b", 6'd1);
        op(3'b000, 1, 0, 6'd0, 8'h00);
        idle(5);
        rd_chk("R2 cyc hold", 6'd1);
        op(3'b000, 1, 0, 6'd0, 8'h01);

        // R3: high half is the one captured at the low read
        rd_chk("R3 lo read", 6'd1);
        hi_cap = m_shadow;
        idle(300);
        rd_chk("R3 hi coherent", 6'd2); check("R3 hi captured", rdata, hi_cap);

        // R9: unmapped reads zero, rdata holds between reads
        rd_chk("R9 unmapped", 6'd63); check("R9 unmapped lit", rdata, 8'h00);
        rd_chk("R9 misc gap", 6'd5);
        idle(3);
        check("R9 hold", rdata, m_rdata);

        // R7: clear zeroes counts and flags but keeps configuration
        op(3'b000, 1, 0, 6'd0, 8'h03);
        rd_chk("R7 cyc cleared", 6'd1);
        rd_chk("R7 cnt cleared", 6'd17); check("R7 cnt lit", rdata, 8'h00);
        rd_chk("R7 cfg kept", 6'd32);    check("R7 cfg lit", rdata, 8'h09);
        rd_chk("R7 run kept", 6'd0);     check("R7 run lit", rdata, 8'h01);

        // Random mix checked against the model (R2 R3 R4 R5 R6 R7 R8 R9)
        for (int it = 0; it < 6000; it++) begin
            logic [2:0] ev = 3'($urandom % 8);
            int sel = int'($urandom % 16);
            if (sel < 6) begin
                op(ev, 0, 1, AW'($urandom % 64), '0);
                check("R4 random read", rdata, m_rdata);
            end else if (sel < 9) begin
                logic [DW-1:0] v = ($urandom % 2 == 0) ? DW'(8'hFC + $urandom % 4) : DW'($urandom);
                op(ev, 1, 0, AW'(16 + $urandom % NC), v);
            end else if (sel < 11) begin
                op(ev, 1, 0, AW'(32 + $urandom % NC), DW'($urandom % 32));
            end else if (sel == 11) begin
                op(ev, 1, 0, 6'd0, {6'd0, ($urandom % 25 == 0), ($urandom % 4 != 0)});
            end else begin
                op(ev, 0, 0, '0, '0);
            end
        end
        for (int i = 0; i < NC; i++) begin
            rd_chk("R6 final cnt", AW'(16 + i));
            rd_chk("R6 final cfg", AW'(32 + i));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule